// File: doc/BRIEF.md
# Sensor Timing SYNC Mode Controller

This block sits between the pattern logic of a CCD-style timing generator and its output pins. It decides how an external, active-low, asynchronous SYNC input acts on the timing: it issues counter reset pulses, and during an enhanced SYNC interval it gates the vertical transfer, sensor-gate, VD, HD and serial-change-point requests. The V, VSG, VD, HD and SCP0 waveforms come from upstream as plain request inputs. The block returns them either unchanged or masked.

There are three behaviours. In normal resynchronization, only the return of SYNC to high resets the horizontal counter, the vertical counter and the field designator. In the enhanced hold mode, the vertical outputs are parked at their programmed sequence-0 start polarities for the whole low interval and the sensor gates are silenced. In the enhanced run mode, the vertical outputs keep running. Both enhanced modes reset the counters on the falling edge of SYNC and again on its rising edge. Both can also mask VD and HD, and both hold SCP0 at zero.

The configuration is four bits taken from a control byte (byte bits 6:3). The block captures these bits when SYNC falls, so one interval always runs under one setting.

The FSM has three states:
- `ST_IDLE`: SYNC is high.
- `ST_NORM_LOW`: SYNC is low in normal mode.
- `ST_ENH_LOW`: the enhanced interval.

It has four transitions:
- ENTER_NORM: `ST_IDLE` to `ST_NORM_LOW`, on a fall with the enable bit clear.
- ENTER_ENH: `ST_IDLE` to `ST_ENH_LOW`, on a fall with the enable bit set, with a reset pulse.
- LEAVE_NORM: `ST_NORM_LOW` to `ST_IDLE`, on a rise, with a reset pulse.
- LEAVE_ENH: `ST_ENH_LOW` to `ST_IDLE`, on a rise, with a reset pulse.

Top module: `sync_mode_ctrl`

## Requirements
- R1: After reset, the block is in `ST_IDLE`, `ctr_rst` and `sync_active` are 0, and every output equals its request input.
- R2: SYNC passes through a two-stage synchronizer and an edge register, so a level driven before clock edge k is acted on at edge k+2. In normal mode (`mode_cfg[0]`=0 at the fall), the fall produces no pulse. The following rise produces exactly one one-cycle `ctr_rst` pulse.
- R3: In enhanced mode (`mode_cfg[0]`=1 at the fall), `ctr_rst` pulses for one cycle on entering the interval and again on leaving it. `sync_active` is 1 from the entry pulse until the edge of the exit pulse.
- R4: While `sync_active` is 1, `scp0_out` is 0.
- R5: While `sync_active` is 1 and the captured VD mask bit (`mode_cfg[2]`) is 1, `vd_out` is 0. When that bit is 0, `vd_out` follows `vd_req`.
- R6: While `sync_active` is 1 and the captured HD mask bit (`mode_cfg[3]`) is 1, `hd_out` is 0. When that bit is 0, `hd_out` follows `hd_req`.
- R7: Hold mode is an interval where the captured V-run bit (`mode_cfg[1]`) is 0. In hold mode, `v_out` equals `seq0_pol` and `vsg_out` is all zero.
- R8: Run mode is an interval where the captured V-run bit is 1. In run mode, `v_out` follows `v_req` and `vsg_out` follows `vsg_req`.
- R9: `mode_cfg` is captured at the falling edge of SYNC. Changes to it during a low interval have no effect until the next fall.
- R10: While `sync_active` is 0, every output equals its request input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | External SYNC, active low, asynchronous |
| mode_cfg | input | 4 | Control byte bits 6:3. Bit 0: enhanced enable. Bit 1: V run (run mode when 1). Bit 2: VD mask. Bit 3: HD mask |
| seq0_pol | input | NV | Sequence-0 start polarities of the V outputs |
| v_req | input | NV | Vertical transfer requests |
| vsg_req | input | NSG | Sensor-gate requests |
| vd_req | input | 1 | VD request |
| hd_req | input | 1 | HD request |
| scp0_req | input | 1 | Serial-change-point 0 request |
| v_out | output | NV | Gated vertical outputs |
| vsg_out | output | NSG | Gated sensor-gate outputs |
| vd_out | output | 1 | Gated VD |
| hd_out | output | 1 | Gated HD |
| scp0_out | output | 1 | Gated SCP0 |
| ctr_rst | output | 1 | One-cycle counter and field-designator reset |
| sync_active | output | 1 | High during an enhanced SYNC interval |

## Verification
The bench builds the block with NV=6 and NSG=3, which differ from the defaults. A wrong slice or swapped index in the per-line gating therefore shows up on lines that a square 4-by-2 build would hide. SYNC_STAGES stays at 2, which keeps the edge-to-action latency of R2 at the value the bench model assumes. The configuration changes at random while SYNC is low, which reaches the capture rule of R9. One-cycle SYNC glitches reach back-to-back entry and exit pulses.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_NORM_LOW = 2'd1,
        ST_ENH_LOW  = 2'd2
    } sync_state_e;

    // Bit order matches control byte bits 6:3 (enable is the lowest).
    typedef struct packed {
        logic hd_mask;
        logic vd_mask;
        logic v_run;
        logic enh_en;
    } sync_cfg_t;

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic level,
    output logic fall,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain   <= '1;
            level_d <= 1'b1;
        end else begin
            chain   <= {chain[STAGES-2:0], async_n};
            level_d <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign fall  = level_d & ~level;
    assign rise  = ~level_d & level;
endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
    import sync_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fall,
    input  logic        rise,
    input  sync_cfg_t   cfg_in,
    output sync_state_e state,
    output sync_cfg_t   snap,
    output logic        ctr_rst
);
    sync_state_e nxt;
    logic        pulse;

    always_comb begin
        nxt   = state;
        pulse = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (fall) begin
                    if (cfg_in.enh_en) begin
                        nxt   = ST_ENH_LOW;   // ENTER_ENH
                        pulse = 1'b1;
                    end else begin
                        nxt   = ST_NORM_LOW;  // ENTER_NORM
                    end
                end
            end
            ST_NORM_LOW: begin
                if (rise) begin
                    nxt   = ST_IDLE;          // LEAVE_NORM
                    pulse = 1'b1;
                end
            end
            ST_ENH_LOW: begin
                if (rise) begin
                    nxt   = ST_IDLE;          // LEAVE_ENH
                    pulse = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            snap  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && fall) begin
                snap <= cfg_in;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_rst <= 1'b0;
        end else begin
            ctr_rst <= pulse;
        end
    end
endmodule

// File: rtl/out_gate.sv
module out_gate
    import sync_mode_pkg::*;
#(
    parameter int NV  = 4,
    parameter int NSG = 2
) (
    input  logic            active,
    input  sync_cfg_t       snap,
    input  logic [NV-1:0]   seq0_pol,
    input  logic [NV-1:0]   v_req,
    input  logic [NSG-1:0]  vsg_req,
    input  logic            vd_req,
    input  logic            hd_req,
    input  logic            scp0_req,
    output logic [NV-1:0]   v_out,
    output logic [NSG-1:0]  vsg_out,
    output logic            vd_out,
    output logic            hd_out,
    output logic            scp0_out
);
    logic hold;
    assign hold = active & ~snap.v_run;

    for (genvar g = 0; g < NV; g++) begin : g_v
        assign v_out[g] = hold ? seq0_pol[g] : v_req[g];
    end

    for (genvar s = 0; s < NSG; s++) begin : g_sg
        assign vsg_out[s] = vsg_req[s] & ~hold;
    end

    assign vd_out   = vd_req & ~(active & snap.vd_mask);
    assign hd_out   = hd_req & ~(active & snap.hd_mask);
    assign scp0_out = scp0_req & ~active;
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
    import sync_mode_pkg::*;
#(
    parameter int NV          = 4,
    parameter int NSG         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_n,
    input  logic [3:0]      mode_cfg,
    input  logic [NV-1:0]   seq0_pol,
    input  logic [NV-1:0]   v_req,
    input  logic [NSG-1:0]  vsg_req,
    input  logic            vd_req,
    input  logic            hd_req,
    input  logic            scp0_req,
    output logic [NV-1:0]   v_out,
    output logic [NSG-1:0]  vsg_out,
    output logic            vd_out,
    output logic            hd_out,
    output logic            scp0_out,
    output logic            ctr_rst,
    output logic            sync_active
);
    logic        sync_lvl;
    logic        sync_fall;
    logic        sync_rise;
    sync_state_e state;
    sync_cfg_t   snap_cfg;
    sync_cfg_t   cfg_in;
    logic        unused_lvl;

    assign cfg_in     = sync_cfg_t'(mode_cfg);
    assign unused_lvl = sync_lvl;

    sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (sync_n),
        .level   (sync_lvl),
        .fall    (sync_fall),
        .rise    (sync_rise)
    );

    sync_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall    (sync_fall),
        .rise    (sync_rise),
        .cfg_in  (cfg_in),
        .state   (state),
        .snap    (snap_cfg),
        .ctr_rst (ctr_rst)
    );

    assign sync_active = (state == ST_ENH_LOW);

    out_gate #(.NV(NV), .NSG(NSG)) u_gate (
        .active   (sync_active),
        .snap     (snap_cfg),
        .seq0_pol (seq0_pol),
        .v_req    (v_req),
        .vsg_req  (vsg_req),
        .vd_req   (vd_req),
        .hd_req   (hd_req),
        .scp0_req (scp0_req),
        .v_out    (v_out),
        .vsg_out  (vsg_out),
        .vd_out   (vd_out),
        .hd_out   (hd_out),
        .scp0_out (scp0_out)
    );
endmodule

// File: rtl/sync_mode_chk.sv
module sync_mode_chk
    import sync_mode_pkg::*;
#(
    parameter int NV  = 4,
    parameter int NSG = 2
) (
    input logic           clk,
    input logic           rst_n,
    input sync_cfg_t      snap,
    input logic [NV-1:0]  seq0_pol,
    input logic [NV-1:0]  v_req,
    input logic [NSG-1:0] vsg_req,
    input logic           vd_req,
    input logic           hd_req,
    input logic           scp0_req,
    input logic [NV-1:0]  v_out,
    input logic [NSG-1:0] vsg_out,
    input logic           vd_out,
    input logic           hd_out,
    input logic           scp0_out,
    input logic           ctr_rst,
    input logic           sync_active
);
    a_r3_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_active) |-> ctr_rst);
    a_r3_exit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_active) |-> ctr_rst);
    a_r4_scp0_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sync_active |-> !scp0_out);
    a_r5_vd_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_active && snap.vd_mask) |-> !vd_out);
    a_r6_hd_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_active && snap.hd_mask) |-> !hd_out);
    a_r7_hold_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_active && !snap.v_run) |-> (v_out == seq0_pol && vsg_out == '0));
    a_r8_run_through: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_active && snap.v_run) |-> (v_out == v_req && vsg_out == vsg_req));
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_active && $past(sync_active)) |-> $stable(snap));
    a_r10_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_active |-> (v_out == v_req && vsg_out == vsg_req && vd_out == vd_req
                          && hd_out == hd_req && scp0_out == scp0_req));
endmodule

bind sync_mode_ctrl sync_mode_chk #(.NV(NV), .NSG(NSG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snap        (snap_cfg),
    .seq0_pol    (seq0_pol),
    .v_req       (v_req),
    .vsg_req     (vsg_req),
    .vd_req      (vd_req),
    .hd_req      (hd_req),
    .scp0_req    (scp0_req),
    .v_out       (v_out),
    .vsg_out     (vsg_out),
    .vd_out      (vd_out),
    .hd_out      (hd_out),
    .scp0_out    (scp0_out),
    .ctr_rst     (ctr_rst),
    .sync_active (sync_active)
);

// File: tb/tb_sync_mode_ctrl.sv
module tb_sync_mode_ctrl;
    localparam int NV  = 6;
    localparam int NSG = 3;
    localparam int ST  = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           sync_n;
    logic [3:0]     mode_cfg;
    logic [NV-1:0]  seq0_pol, v_req, v_out;
    logic [NSG-1:0] vsg_req, vsg_out;
    logic           vd_req, hd_req, scp0_req;
    logic           vd_out, hd_out, scp0_out, ctr_rst, sync_active;

    int checks = 0;
    int errors = 0;
    string tag_force = "";

    // Bench model state
    logic [ST-1:0] m_chain;
    logic          m_d;
    int            m_state;   // 0 idle, 1 normal low, 2 enhanced
    logic [3:0]    m_snap;
    logic          m_rst;

    always #10 clk = ~clk;

    sync_mode_ctrl #(.NV(NV), .NSG(NSG), .SYNC_STAGES(ST)) dut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .mode_cfg(mode_cfg),
        .seq0_pol(seq0_pol), .v_req(v_req), .vsg_req(vsg_req), .vd_req(vd_req),
        .hd_req(hd_req), .scp0_req(scp0_req), .v_out(v_out), .vsg_out(vsg_out),
        .vd_out(vd_out), .hd_out(hd_out), .scp0_out(scp0_out),
        .ctr_rst(ctr_rst), .sync_active(sync_active)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NV-1:0] exp_v(input logic act, input logic [3:0] sn,
                                            input logic [NV-1:0] pol, input logic [NV-1:0] rq);
        return (act && !sn[1]) ? pol : rq;
    endfunction

    function automatic logic [NSG-1:0] exp_sg(input logic act, input logic [3:0] sn,
                                              input logic [NSG-1:0] rq);
        return (act && !sn[1]) ? '0 : rq;
    endfunction

    function automatic logic exp_bit(input logic act, input logic msk, input logic rq);
        return (act && msk) ? 1'b0 : rq;
    endfunction

    task automatic model_reset();
        m_chain = '1; m_d = 1'b1; m_state = 0; m_snap = '0; m_rst = 1'b0;
    endtask

    task automatic model_step();
        logic lvl, f, r;
        lvl = m_chain[ST-1];
        f = m_d & ~lvl;
        r = ~m_d & lvl;
        m_rst = 1'b0;
        case (m_state)
            0: if (f) begin
                   m_snap = mode_cfg;
                   if (mode_cfg[0]) begin m_state = 2; m_rst = 1'b1; end
                   else m_state = 1;
               end
            default: if (r) begin m_state = 0; m_rst = 1'b1; end
        endcase
        m_d = lvl;
        m_chain = {m_chain[ST-2:0], sync_n};
    endtask

    task automatic check_all();
        logic  a;
        string tv, tr;
        a  = (m_state == 2);
        tv = a ? (m_snap[1] ? "R8" : "R7") : "R10";
        tr = (m_snap[0] && (m_state == 2 || m_rst && m_state == 0)) ? "R3" : "R2";
        if (tag_force != "") begin tv = tag_force; tr = tag_force; end
        check(tr, "ctr_rst", 32'(ctr_rst), 32'(m_rst));
        check(tr, "sync_active", 32'(sync_active), 32'(a));
        check(tv, "v_out", 32'(v_out), 32'(exp_v(a, m_snap, seq0_pol, v_req)));
        check(tv, "vsg_out", 32'(vsg_out), 32'(exp_sg(a, m_snap, vsg_req)));
        check(a ? "R5" : "R10", "vd_out", 32'(vd_out), 32'(exp_bit(a, m_snap[2], vd_req)));
        check(a ? "R6" : "R10", "hd_out", 32'(hd_out), 32'(exp_bit(a, m_snap[3], hd_req)));
        check(a ? "R4" : "R10", "scp0_out", 32'(scp0_out), 32'(exp_bit(a, 1'b1, scp0_req)));
    endtask

    task automatic rand_reqs();
        seq0_pol = NV'($urandom);
        v_req    = NV'($urandom);
        vsg_req  = NSG'($urandom);
        vd_req   = 1'($urandom);
        hd_req   = 1'($urandom);
        scp0_req = 1'($urandom);
    endtask

    // One clock: model update at the edge, new stimulus at the falling edge, check after.
    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        rand_reqs();
        #1;
        check_all();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7041));
        rst_n = 1'b0; sync_n = 1'b1; mode_cfg = 4'h0;
        rand_reqs();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        tag_force = "R1";
        check_all();
        tag_force = "";

        // Directed R2: normal mode pulse on the rise only
        mode_cfg = 4'b0000;
        repeat (4) cycle();
        sync_n = 1'b0;
        repeat (6) cycle();
        sync_n = 1'b1;
        repeat (6) cycle();

        // Directed R9: hold mode entered, configuration cleared mid-interval
        mode_cfg = 4'b1101;
        sync_n = 1'b0;
        repeat (5) cycle();
        mode_cfg = 4'b0000;
        tag_force = "R9";
        repeat (6) cycle();
        tag_force = "";
        sync_n = 1'b1;
        repeat (6) cycle();

        // Directed R8: run mode with masks off
        mode_cfg = 4'b0011;
        sync_n = 1'b0;
        repeat (6) cycle();
        sync_n = 1'b1;
        repeat (6) cycle();

        // Constrained random: rare SYNC toggles, occasional configuration changes
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0) sync_n = ~sync_n;
            if ($urandom_range(0, 3) == 0) mode_cfg = 4'($urandom);
            cycle();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule